// File: doc/BRIEF.md
# Low-Power Operating Mode Sequencer

This block tracks the operating mode of the chip. There are two run modes, NORMAL (high-speed clock) and SLOW (low-speed clock), and three standby modes, IDLE, SLEEP and STOP. The core asks for standby with a halt pulse or a doze pulse. A halt request is resolved through a 2-bit standby select field. A doze request always gives IDLE. Software-issued switch requests move the chip between the two run modes. A wake-up interrupt that is already qualified by the interrupt controller ends any standby mode.

The mode left after SLEEP or IDLE is the run mode that was active before entry. The mode left after STOP is picked by a configuration bit. Each exit from SLEEP or STOP produces a one-cycle pulse that starts the external oscillator warm-up timer. The CPU clock stays gated until the warm-up-done input arrives. From the current mode the block decodes five domain enables: CPU clock, high-speed oscillator, low-speed oscillator, aggregate peripheral clock, and real-time-clock domain. The real-time-clock domain also covers the pulse counter and the key wake-up logic.

Top module: `stby_mode_ctrl`

## Requirements
- R1: While reset is active and after it is released, the mode code is NORMAL. All five domain enables are 1 and `warm_start` is 0. Mode codes on `mode_o` are NORMAL=0, SLOW=1, IDLE=2, SLEEP=3 and STOP=4.
- R2: A halt pulse taken in a run mode enters a standby mode one cycle later. The mode depends on `stby_sel`: 01 gives STOP, 10 gives SLEEP, and 11 or the reserved 00 gives IDLE.
- R3: A doze pulse taken in a run mode enters IDLE whatever `stby_sel` holds, and it takes priority over a simultaneous halt.
- R4: `wake_irq` high in IDLE, SLEEP or STOP leaves standby on the next cycle. In NORMAL or SLOW it has no effect.
- R5: Leaving IDLE or SLEEP returns to the run mode (NORMAL or SLOW) that was active when standby was entered.
- R6: Leaving STOP enters SLOW when `stop_to_slow` is 1 and NORMAL when it is 0.
- R7: A request to enter SLOW, or a halt that selects SLEEP, is refused while `fs_stable` is 0. A refused request leaves the mode unchanged.
- R8: The enables, listed as {cpu, hosc, losc, periph, rtc}, follow the mode:
  - NORMAL: 11111
  - SLOW: 10101
  - IDLE entered from NORMAL: 01111
  - IDLE entered from SLOW: 00101
  - SLEEP: 00101
  - STOP: 00000
- R9: On every exit from SLEEP or STOP, `warm_start` is 1 for exactly the first cycle in the new mode. Until `warm_done` is sampled high, `cpu_clk_en` and `periph_en` are 0 and halt, doze and switch requests are ignored. During this wait `hosc_en` is 1 only when the target is NORMAL. The enables of the target mode apply from the cycle after `warm_done` is sampled.
- R10: `go_normal` moves SLOW to NORMAL and `go_slow` moves NORMAL to SLOW, each one cycle later. In any other mode neither request has an effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| halt_req | input | 1 | Standby request resolved through `stby_sel` |
| doze_req | input | 1 | Standby request that always selects IDLE |
| stby_sel | input | 2 | Standby select: 01 STOP, 10 SLEEP, 11/00 IDLE |
| go_slow | input | 1 | Request to switch NORMAL to SLOW |
| go_normal | input | 1 | Request to switch SLOW to NORMAL |
| wake_irq | input | 1 | Qualified wake-up interrupt |
| fs_stable | input | 1 | Low-speed oscillator reports stable |
| warm_done | input | 1 | Warm-up timer has expired |
| stop_to_slow | input | 1 | Run mode after STOP: 1 SLOW, 0 NORMAL |
| mode_o | output | 3 | Current mode code |
| cpu_clk_en | output | 1 | CPU clock enable |
| hosc_en | output | 1 | High-speed oscillator enable |
| losc_en | output | 1 | Low-speed oscillator enable |
| periph_en | output | 1 | Aggregate peripheral clock enable |
| rtc_en | output | 1 | Real-time-clock, pulse counter and key wake-up domain enable |
| warm_start | output | 1 | One-cycle pulse that starts the warm-up timer |

## Verification
Every request is sampled at one rising edge, and the new mode, the decoded enables and the `warm_start` pulse all appear right after that edge. Each result is therefore due one cycle after its stimulus. The `cpu_clk_en` release is due one cycle after `warm_done` is sampled. The bench applies each stimulus on a falling edge and queues the values due after the next rising edge. The comparison runs shortly after that rising edge, so every expected item is matched against exactly the cycle in which the registered state has moved.

// File: rtl/stby_pkg.sv
package stby_pkg;

    localparam int MODE_W  = 3;
    localparam int SEL_W   = 2;
    localparam int NUM_DOM = 5;

    // domain bit positions in the enable vector
    localparam int DOM_RTC  = 0;
    localparam int DOM_PER  = 1;
    localparam int DOM_LOSC = 2;
    localparam int DOM_HOSC = 3;
    localparam int DOM_CPU  = 4;

    // standby select codes
    localparam logic [SEL_W-1:0] SEL_RSVD  = 2'b00;
    localparam logic [SEL_W-1:0] SEL_STOP  = 2'b01;
    localparam logic [SEL_W-1:0] SEL_SLEEP = 2'b10;
    localparam logic [SEL_W-1:0] SEL_IDLE  = 2'b11;

    typedef enum logic [MODE_W-1:0] {
        MD_NORMAL = 3'd0,
        MD_SLOW   = 3'd1,
        MD_IDLE   = 3'd2,
        MD_SLEEP  = 3'd3,
        MD_STOP   = 3'd4
    } mode_e;

    typedef enum logic [2:0] {
        ACT_NONE,
        ACT_IDLE,
        ACT_SLEEP,
        ACT_STOP,
        ACT_SLOW,
        ACT_NORMAL
    } act_e;

    typedef struct packed {
        mode_e mode;       // current mode
        mode_e home;       // run mode to return to from IDLE/SLEEP
        logic  warming;    // waiting for oscillator warm-up
        logic  warm_pulse; // first cycle after SLEEP/STOP exit
    } st_t;

    localparam st_t ST_RESET = '{
        mode:       MD_NORMAL,
        home:       MD_NORMAL,
        warming:    1'b0,
        warm_pulse: 1'b0
    };

    function automatic logic is_run(mode_e m);
        return (m == MD_NORMAL) || (m == MD_SLOW);
    endfunction

    // per-domain enable decode
    function automatic logic dom_on(int d, mode_e m, mode_e h, logic w);
        logic on;
        case (d)
            DOM_CPU:  on = is_run(m) && !w;
            DOM_HOSC: on = (m == MD_NORMAL) || ((m == MD_IDLE) && (h == MD_NORMAL));
            DOM_LOSC: on = (m != MD_STOP);
            DOM_PER:  on = ((m == MD_NORMAL) && !w) ||
                           ((m == MD_IDLE) && (h == MD_NORMAL));
            DOM_RTC:  on = (m != MD_STOP);
            default:  on = 1'b0;
        endcase
        return on;
    endfunction

endpackage

// File: rtl/stby_req_arb.sv
module stby_req_arb
    import stby_pkg::*;
(
    input  mode_e             mode_i,
    input  logic              warming_i,
    input  logic              halt_i,
    input  logic              doze_i,
    input  logic [SEL_W-1:0]  sel_i,
    input  logic              fs_ok_i,
    input  logic              go_slow_i,
    input  logic              go_normal_i,
    output act_e              act_o
);

    act_e halt_act;

    // resolve the standby select field for a halt request
    always_comb begin
        case (sel_i)
            SEL_STOP:  halt_act = ACT_STOP;
            SEL_SLEEP: halt_act = fs_ok_i ? ACT_SLEEP : ACT_NONE;
            SEL_IDLE:  halt_act = ACT_IDLE;
            SEL_RSVD:  halt_act = ACT_IDLE;
            default:   halt_act = ACT_IDLE;
        endcase
    end

    // priority: doze, halt, clock switch
    always_comb begin
        act_o = ACT_NONE;
        if (is_run(mode_i) && !warming_i) begin
            if (doze_i) begin
                act_o = ACT_IDLE;
            end else if (halt_i) begin
                act_o = halt_act;
            end else if (go_slow_i && (mode_i == MD_NORMAL) && fs_ok_i) begin
                act_o = ACT_SLOW;
            end else if (go_normal_i && (mode_i == MD_SLOW)) begin
                act_o = ACT_NORMAL;
            end
        end
    end

endmodule

// File: rtl/stby_fsm.sv
module stby_fsm
    import stby_pkg::*;
(
    input  logic  clk,
    input  logic  rst_n,
    input  act_e  act_i,
    input  logic  wake_i,
    input  logic  warm_done_i,
    input  logic  stop_to_slow_i,
    output st_t   st_o
);

    st_t st_d;
    st_t st_q;

    always_comb begin
        st_d            = st_q;
        st_d.warm_pulse = 1'b0;
        case (st_q.mode)
            MD_NORMAL, MD_SLOW: begin
                if (st_q.warming) begin
                    if (warm_done_i) begin
                        st_d.warming = 1'b0;
                    end
                end else begin
                    case (act_i)
                        ACT_IDLE: begin
                            st_d.mode = MD_IDLE;
                            st_d.home = st_q.mode;
                        end
                        ACT_SLEEP: begin
                            st_d.mode = MD_SLEEP;
                            st_d.home = st_q.mode;
                        end
                        ACT_STOP: begin
                            st_d.mode = MD_STOP;
                            st_d.home = st_q.mode;
                        end
                        ACT_SLOW:   st_d.mode = MD_SLOW;
                        ACT_NORMAL: st_d.mode = MD_NORMAL;
                        default:    st_d.mode = st_q.mode;
                    endcase
                end
            end
            MD_IDLE: begin
                if (wake_i) begin
                    st_d.mode = st_q.home;
                end
            end
            MD_SLEEP: begin
                if (wake_i) begin
                    st_d.mode       = st_q.home;
                    st_d.warming    = 1'b1;
                    st_d.warm_pulse = 1'b1;
                end
            end
            MD_STOP: begin
                if (wake_i) begin
                    st_d.mode       = stop_to_slow_i ? MD_SLOW : MD_NORMAL;
                    st_d.warming    = 1'b1;
                    st_d.warm_pulse = 1'b1;
                end
            end
            default: st_d = ST_RESET;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= ST_RESET;
        end else begin
            st_q <= st_d;
        end
    end

    assign st_o = st_q;

endmodule

// File: rtl/stby_dom_dec.sv
module stby_dom_dec
    import stby_pkg::*;
#(
    parameter int N_DOM = NUM_DOM
) (
    input  mode_e              mode_i,
    input  mode_e              home_i,
    input  logic               warming_i,
    output logic [N_DOM-1:0]   en_o
);

    for (genvar d = 0; d < N_DOM; d++) begin : g_dom
        assign en_o[d] = dom_on(d, mode_i, home_i, warming_i);
    end

endmodule

// File: rtl/stby_mode_ctrl.sv
module stby_mode_ctrl
    import stby_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              halt_req,
    input  logic              doze_req,
    input  logic [SEL_W-1:0]  stby_sel,
    input  logic              go_slow,
    input  logic              go_normal,
    input  logic              wake_irq,
    input  logic              fs_stable,
    input  logic              warm_done,
    input  logic              stop_to_slow,
    output logic [MODE_W-1:0] mode_o,
    output logic              cpu_clk_en,
    output logic              hosc_en,
    output logic              losc_en,
    output logic              periph_en,
    output logic              rtc_en,
    output logic              warm_start
);

    st_t               st;
    act_e              act;
    logic [NUM_DOM-1:0] dom_en;
    logic              warming;

    stby_req_arb u_arb (
        .mode_i      (st.mode),
        .warming_i   (st.warming),
        .halt_i      (halt_req),
        .doze_i      (doze_req),
        .sel_i       (stby_sel),
        .fs_ok_i     (fs_stable),
        .go_slow_i   (go_slow),
        .go_normal_i (go_normal),
        .act_o       (act)
    );

    stby_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .act_i          (act),
        .wake_i         (wake_irq),
        .warm_done_i    (warm_done),
        .stop_to_slow_i (stop_to_slow),
        .st_o           (st)
    );

    stby_dom_dec #(.N_DOM(NUM_DOM)) u_dec (
        .mode_i    (st.mode),
        .home_i    (st.home),
        .warming_i (st.warming),
        .en_o      (dom_en)
    );

    assign warming    = st.warming;
    assign mode_o     = st.mode;
    assign warm_start = st.warm_pulse;
    assign cpu_clk_en = dom_en[DOM_CPU];
    assign hosc_en    = dom_en[DOM_HOSC];
    assign losc_en    = dom_en[DOM_LOSC];
    assign periph_en  = dom_en[DOM_PER];
    assign rtc_en     = dom_en[DOM_RTC];

endmodule

// File: rtl/stby_mode_ctrl_chk.sv
module stby_mode_ctrl_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       doze_req,
    input logic       wake_irq,
    input logic       fs_stable,
    input logic       stop_to_slow,
    input logic [2:0] mode_o,
    input logic       cpu_clk_en,
    input logic       hosc_en,
    input logic       losc_en,
    input logic       periph_en,
    input logic       rtc_en,
    input logic       warm_start,
    input logic       warming
);

    // R3
    doze_to_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (doze_req && (mode_o <= 3'd1) && !warming) |=> (mode_o == 3'd2));

    // R4
    wake_leaves_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (wake_irq && (mode_o >= 3'd2)) |=> (mode_o <= 3'd1));

    // R6
    stop_exit_sel_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (($past(mode_o) == 3'd4) && (mode_o != 3'd4))
        |-> (mode_o == ($past(stop_to_slow) ? 3'd1 : 3'd0)));

    // R7
    slow_needs_fs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((mode_o == 3'd1) && ($past(mode_o) == 3'd0)) |-> $past(fs_stable));

    // R8
    stop_all_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_o == 3'd4)
        |-> ($countones({cpu_clk_en, hosc_en, losc_en, periph_en, rtc_en}) == 0));

    // R9
    warm_from_deep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        warm_start |-> (($past(mode_o) == 3'd3) || ($past(mode_o) == 3'd4)));

    // R9
    cpu_gated_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_clk_en |-> ((mode_o <= 3'd1) && !warming));

endmodule

bind stby_mode_ctrl stby_mode_ctrl_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .doze_req     (doze_req),
    .wake_irq     (wake_irq),
    .fs_stable    (fs_stable),
    .stop_to_slow (stop_to_slow),
    .mode_o       (mode_o),
    .cpu_clk_en   (cpu_clk_en),
    .hosc_en      (hosc_en),
    .losc_en      (losc_en),
    .periph_en    (periph_en),
    .rtc_en       (rtc_en),
    .warm_start   (warm_start),
    .warming      (warming)
);

// File: tb/stby_mode_ctrl_tb_top.sv
`timescale 1ns/1ps
module stby_mode_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       halt_req = 1'b0, doze_req = 1'b0, go_slow = 1'b0, go_normal = 1'b0;
    logic       wake_irq = 1'b0, fs_stable = 1'b1, warm_done = 1'b0, stop_to_slow = 1'b0;
    logic [1:0] stby_sel = 2'b11;
    logic [2:0] mode_o;
    logic       cpu_clk_en, hosc_en, losc_en, periph_en, rtc_en, warm_start;

    always #5 clk = ~clk;

    stby_mode_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .halt_req(halt_req), .doze_req(doze_req),
        .stby_sel(stby_sel), .go_slow(go_slow), .go_normal(go_normal),
        .wake_irq(wake_irq), .fs_stable(fs_stable), .warm_done(warm_done),
        .stop_to_slow(stop_to_slow), .mode_o(mode_o), .cpu_clk_en(cpu_clk_en),
        .hosc_en(hosc_en), .losc_en(losc_en), .periph_en(periph_en),
        .rtc_en(rtc_en), .warm_start(warm_start)
    );

    // {cpu, hosc, losc, periph, rtc}
    localparam logic [4:0] EN_NORM   = 5'b11111;
    localparam logic [4:0] EN_SLOW   = 5'b10101;
    localparam logic [4:0] EN_IDLE_N = 5'b01111;
    localparam logic [4:0] EN_IDLE_S = 5'b00101;
    localparam logic [4:0] EN_SLEEP  = 5'b00101;
    localparam logic [4:0] EN_STOP   = 5'b00000;
    localparam logic [4:0] EN_WARM_N = 5'b01101;
    localparam logic [4:0] EN_WARM_S = 5'b00101;

    localparam logic [2:0] M_NORM = 3'd0, M_SLOW = 3'd1, M_IDLE = 3'd2,
                           M_SLEEP = 3'd3, M_STOP = 3'd4;

    typedef struct {
        logic [2:0] m;
        logic [4:0] en;
        logic       ws;
        string      tag;
    } exp_t;

    exp_t exp_q[$];
    int   n_chk  = 0;
    int   n_fail = 0;
    bit   done   = 1'b0;

    function automatic logic [4:0] en_now();
        return {cpu_clk_en, hosc_en, losc_en, periph_en, rtc_en};
    endfunction

    task automatic compare(input exp_t e);
        n_chk++;
        if (mode_o !== e.m || en_now() !== e.en || warm_start !== e.ws) begin
            n_fail++;
            $display("FAIL %s: got mode=%0d en=%b ws=%b, expected mode=%0d en=%b ws=%b",
                     e.tag, mode_o, en_now(), warm_start, e.m, e.en, e.ws);
        end
    endtask

    // driver: apply one cycle of stimulus, queue the result due after the next edge
    task automatic run(input logic h, input logic dz, input logic [1:0] sel,
                       input logic wk, input logic fs, input logic wd,
                       input logic ret, input logic gs, input logic gn,
                       input logic [2:0] em, input logic [4:0] een,
                       input logic ews, input string tag);
        exp_t e;
        @(negedge clk);
        halt_req = h; doze_req = dz; stby_sel = sel; wake_irq = wk;
        fs_stable = fs; warm_done = wd; stop_to_slow = ret;
        go_slow = gs; go_normal = gn;
        e.m = em; e.en = een; e.ws = ews; e.tag = tag;
        exp_q.push_back(e);
    endtask

    // monitor
    always @(posedge clk) begin
        #2;
        if (exp_q.size() > 0) begin
            compare(exp_q.pop_front());
        end
    end

    // watchdog
    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: got hung run, expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        exp_t r;
        repeat (3) @(posedge clk);
        #2;
        r.m = M_NORM; r.en = EN_NORM; r.ws = 1'b0; r.tag = "R1 in reset";
        compare(r);
        @(negedge clk);
        rst_n = 1'b1;
        //   h  dz sel    wk fs wd rt gs gn   mode     enables    ws
        run(0, 0, 2'b11, 0, 1, 0, 0, 0, 0, M_NORM,  EN_NORM,   0, "R1 after reset");
        run(0, 0, 2'b11, 1, 1, 0, 0, 0, 0, M_NORM,  EN_NORM,   0, "R4 wake in NORMAL ignored");
        run(0, 0, 2'b11, 0, 1, 0, 0, 0, 1, M_NORM,  EN_NORM,   0, "R10 go_normal in NORMAL");
        run(1, 0, 2'b11, 0, 1, 0, 0, 0, 0, M_IDLE,  EN_IDLE_N, 0, "R2 halt sel 11 IDLE");
        run(0, 0, 2'b11, 0, 1, 0, 0, 0, 0, M_IDLE,  EN_IDLE_N, 0, "R8 IDLE from NORMAL");
        run(0, 0, 2'b11, 0, 1, 0, 0, 1, 0, M_IDLE,  EN_IDLE_N, 0, "R10 go_slow in IDLE");
        run(0, 0, 2'b11, 1, 1, 0, 0, 0, 0, M_NORM,  EN_NORM,   0, "R5 IDLE back to NORMAL");
        run(1, 0, 2'b00, 0, 1, 0, 0, 0, 0, M_IDLE,  EN_IDLE_N, 0, "R2 reserved sel 00 IDLE");
        run(0, 0, 2'b11, 1, 1, 0, 0, 0, 0, M_NORM,  EN_NORM,   0, "R4 wake from IDLE");
        run(1, 1, 2'b01, 0, 1, 0, 0, 0, 0, M_IDLE,  EN_IDLE_N, 0, "R3 doze beats STOP select");
        run(0, 0, 2'b11, 1, 1, 0, 0, 0, 0, M_NORM,  EN_NORM,   0, "R4 wake from IDLE");
        run(1, 0, 2'b10, 0, 0, 0, 0, 0, 0, M_NORM,  EN_NORM,   0, "R7 SLEEP refused fs low");
        run(0, 0, 2'b11, 0, 0, 0, 0, 1, 0, M_NORM,  EN_NORM,   0, "R7 SLOW refused fs low");
        run(1, 0, 2'b10, 0, 1, 0, 0, 0, 0, M_SLEEP, EN_SLEEP,  0, "R2 halt sel 10 SLEEP");
        run(0, 0, 2'b11, 0, 1, 0, 0, 0, 0, M_SLEEP, EN_SLEEP,  0, "R8 SLEEP enables");
        run(0, 0, 2'b11, 1, 1, 0, 0, 0, 0, M_NORM,  EN_WARM_N, 1, "R5 SLEEP back to NORMAL");
        run(0, 0, 2'b11, 0, 1, 0, 0, 0, 0, M_NORM,  EN_WARM_N, 0, "R9 still warming");
        run(1, 0, 2'b01, 0, 1, 0, 0, 0, 0, M_NORM,  EN_WARM_N, 0, "R9 halt ignored warming");
        run(0, 0, 2'b11, 0, 1, 1, 0, 0, 0, M_NORM,  EN_NORM,   0, "R9 warm done");
        run(0, 0, 2'b11, 0, 1, 0, 0, 1, 0, M_SLOW,  EN_SLOW,   0, "R10 go_slow to SLOW");
        run(0, 0, 2'b11, 1, 1, 0, 0, 0, 0, M_SLOW,  EN_SLOW,   0, "R4 wake in SLOW ignored");
        run(1, 0, 2'b11, 0, 1, 0, 0, 0, 0, M_IDLE,  EN_IDLE_S, 0, "R8 IDLE from SLOW");
        run(0, 0, 2'b11, 1, 1, 0, 0, 0, 0, M_SLOW,  EN_SLOW,   0, "R5 IDLE back to SLOW");
        run(1, 0, 2'b10, 0, 1, 0, 0, 0, 0, M_SLEEP, EN_SLEEP,  0, "R2 SLEEP from SLOW");
        run(0, 0, 2'b11, 1, 1, 0, 0, 0, 0, M_SLOW,  EN_WARM_S, 1, "R5 SLEEP back to SLOW");
        run(0, 0, 2'b11, 0, 1, 1, 0, 0, 0, M_SLOW,  EN_SLOW,   0, "R9 warm done SLOW");
        run(0, 1, 2'b01, 0, 1, 0, 0, 0, 0, M_IDLE,  EN_IDLE_S, 0, "R3 doze in SLOW");
        run(0, 0, 2'b11, 1, 1, 0, 0, 0, 0, M_SLOW,  EN_SLOW,   0, "R5 IDLE back to SLOW");
        run(0, 0, 2'b11, 0, 1, 0, 0, 0, 1, M_NORM,  EN_NORM,   0, "R10 go_normal to NORMAL");
        run(1, 0, 2'b01, 0, 1, 0, 0, 0, 0, M_STOP,  EN_STOP,   0, "R2 halt sel 01 STOP");
        run(0, 0, 2'b11, 0, 1, 0, 0, 0, 0, M_STOP,  EN_STOP,   0, "R8 STOP all off");
        run(0, 0, 2'b11, 1, 1, 0, 1, 0, 0, M_SLOW,  EN_WARM_S, 1, "R6 STOP exit to SLOW");
        run(0, 0, 2'b11, 0, 1, 1, 0, 0, 0, M_SLOW,  EN_SLOW,   0, "R9 warm done after STOP");
        run(0, 0, 2'b11, 0, 1, 0, 0, 0, 1, M_NORM,  EN_NORM,   0, "R10 back to NORMAL");
        run(1, 0, 2'b01, 0, 1, 0, 0, 0, 0, M_STOP,  EN_STOP,   0, "R2 STOP again");
        run(0, 0, 2'b11, 1, 1, 0, 0, 0, 0, M_NORM,  EN_WARM_N, 1, "R6 STOP exit to NORMAL");
        run(0, 0, 2'b11, 0, 1, 1, 0, 0, 0, M_NORM,  EN_NORM,   0, "R9 warm done NORMAL");
        repeat (3) @(posedge clk);
        #4;
        if (exp_q.size() != 0) begin
            n_fail++;
            $display("FAIL scoreboard: got %0d items left, expected 0", exp_q.size());
        end
        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule